// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block is a target on a 32-bit processor bus where address and data travel on the same lines. While the address-latch strobe is high it captures the upper address bits, the byte offset and a two-bit transfer size. The two word-select bits that pick a word inside an aligned group of four travel on separate lines that the processor drives again for every beat.

A cycle starts when the cycle-in-progress signal is low and a strobe is valid. A read needs the active-low read strobe together with a high direction input. A write needs the active-low write strobe together with a low direction input. Each beat becomes one request on a simple back-side port that carries a word address, byte enables, write data, read data and a ready input. The target waits for ready before it returns an active-low acknowledge for the beat. In a read it drives the shared bus during the acknowledge cycle.

A transfer ends on the beat that carries the active-low last marker, or after four acknowledged beats. After that the target accepts nothing until a new address phase.

Top module: `mux_bus_target`

## Requirements
- R1: While reset is applied and after it is released, `ack_n_o` is high, `bus_ad_oe` is low and `req_valid_o` is low until a cycle starts.
- R2: `req_addr_o[29:2]` equals bus bits 31:4 as they were while `ale_i` was high. Bus values driven after the address phase do not change it.
- R3: `req_addr_o[1:0]` equals the `word_sel_i` lines as they were driven at the start of each beat.
- R4: A read starts only when `rd_n_i` is low with `dir_rd_i` high. A write starts only when `wr_n_i` is low with `dir_rd_i` low. Any other combination raises no request.
- R5: `width_i` is sampled with the address and gives 1, 2, 3 or 4 bytes for the codes 0, 1, 2 and 3. The byte enables `req_be_o[k]` are set for lanes starting at the byte offset (bus bits 1:0) and going upward. Lanes above lane 3 are dropped.
- R6: `ack_n_o` goes low for exactly one cycle, in the cycle after the one in which `req_valid_o` and `req_ready_i` are both high. With W wait cycles before ready, the acknowledge follows the beat start by W+1 cycles.
- R7: In a read, the bus is driven (`bus_ad_oe` high) only during the acknowledge cycle and only while `data_en_n_i` is low. `bus_ad_o` then carries the `req_rdata_i` word that was accepted.
- R8: In a write beat, `req_write_o` is high and `req_wdata_o` follows the shared bus.
- R9: A beat accepted with `last_n_i` low ends the transfer. Strobes held low afterwards raise no request until a new address phase.
- R10: A burst ends after four acknowledged beats even if `last_n_i` never goes low.
- R11: If `cip_n_i` is high after an address phase and before any strobe, the target returns to idle. A later strobe without a new address phase raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_ad_i | input | 32 | Shared address/data lines, as seen by the target |
| bus_ad_o | output | 32 | Read data the target drives onto the shared lines |
| bus_ad_oe | output | 1 | High while the target drives the shared lines |
| ale_i | input | 1 | Address-latch strobe, active high |
| word_sel_i | input | 2 | Separate word-select lines, redriven every beat |
| width_i | input | 2 | Transfer size code, valid with the address |
| cip_n_i | input | 1 | Cycle in progress, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| dir_rd_i | input | 1 | Direction: high means the target sources data |
| data_en_n_i | input | 1 | Processor data-enable, active low; gates the read drive |
| last_n_i | input | 1 | Final-beat marker, active low |
| ack_n_o | output | 1 | Beat acknowledge, active low |
| req_valid_o | output | 1 | Back-side request valid |
| req_write_o | output | 1 | Back-side request is a write |
| req_addr_o | output | 30 | Back-side word address |
| req_be_o | output | 4 | Back-side byte enables |
| req_wdata_o | output | 32 | Back-side write data |
| req_rdata_i | input | 32 | Back-side read data |
| req_ready_i | input | 1 | Back-side ready |

## Verification
Two end conditions can fall on the same beat: the last marker and the four-beat limit. The bench runs a four-beat read burst with `last_n_i` low on the fourth beat. The burst also starts from a nonzero word-select value, so the word index wraps around. The run passes if exactly four acknowledges appear with the expected data and the strobes, still held low, then raise no further request. A second collision is a read acknowledge with the data-enable held off: the acknowledge must still appear while the shared lines stay released.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BEAT  = 2'd2,
    ST_ACK   = 2'd3
  } mbt_state_e;
endpackage

// File: rtl/mbt_addr_latch.sv
module mbt_addr_latch #(
  parameter int DATA_W = 32,
  parameter int WIDX_W = 2,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-$clog2(DATA_W/8)-WIDX_W-1:0] hi_o,
  output logic [$clog2(DATA_W/8)-1:0] boff_o,
  output logic [SIZE_W-1:0] size_o
);
  localparam int LANES  = DATA_W / 8;
  localparam int BOFF_W = $clog2(LANES);
  localparam int HI_W   = DATA_W - BOFF_W - WIDX_W;

  logic [HI_W-1:0]   hi_q;
  logic [BOFF_W-1:0] boff_q;
  logic [SIZE_W-1:0] size_q;

  // capture register with an explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      boff_q <= '0;
      size_q <= '0;
    end else if (cap_en_i) begin
      hi_q   <= bus_i[DATA_W-1:BOFF_W+WIDX_W];
      boff_q <= bus_i[BOFF_W-1:0];
      size_q <= size_i;
    end
  end

  assign hi_o   = hi_q;
  assign boff_o = boff_q;
  assign size_o = size_q;

  // R2: captured address only moves in a cycle after a capture request
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en_i |=> $stable({hi_q, boff_q, size_q}));
endmodule

// File: rtl/mbt_lane_gen.sv
module mbt_lane_gen #(
  parameter int LANES  = 4,
  parameter int SIZE_W = 2
) (
  input  logic [$clog2(LANES)-1:0] boff_i,
  input  logic [SIZE_W-1:0]        size_i,
  output logic [LANES-1:0]         be_o
);
  // each lane is enabled when it lies in [offset, offset + size]
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be_o[l] = (l >= int'(boff_i)) && (l <= int'(boff_i) + int'(size_i));
  end
endmodule

// File: rtl/mbt_fsm.sv
module mbt_fsm
  import mbt_pkg::*;
#(
  parameter int MAX_BEATS = 4,
  parameter int WIDX_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic              cip_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic              dir_rd_i,
  input  logic              last_n_i,
  input  logic [WIDX_W-1:0] word_sel_i,
  input  logic              ready_i,
  output mbt_state_e        state_o,
  output logic              write_o,
  output logic [WIDX_W-1:0] widx_o,
  output logic              cap_en_o,
  output logic              accept_o
);
  localparam int BEAT_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
  localparam logic [BEAT_W-1:0] BEAT_END = BEAT_W'(MAX_BEATS - 1);

  mbt_state_e        state_q, state_d;
  logic              write_q, write_d;
  logic [WIDX_W-1:0] widx_q;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              last_q;
  logic              ld_widx, ld_last, ld_beat;
  logic              start_rd, start_wr, done;

  assign start_rd = !rd_n_i && dir_rd_i;
  assign start_wr = !wr_n_i && !dir_rd_i;
  assign done     = last_q || (beat_q == BEAT_END);

  // next state
  always_comb begin
    state_d = state_q;
    write_d = write_q;
    beat_d  = beat_q;
    ld_widx = 1'b0;
    ld_beat = 1'b0;
    ld_last = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ale_i) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (cip_n_i) begin
          state_d = ST_IDLE;
        end else if (start_rd || start_wr) begin
          state_d = ST_BEAT;
          write_d = start_wr;
          beat_d  = '0;
          ld_beat = 1'b1;
          ld_widx = 1'b1;
        end
      end
      ST_BEAT: begin
        if (ready_i) begin
          state_d = ST_ACK;
          ld_last = 1'b1;
        end
      end
      ST_ACK: begin
        if (done) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_BEAT;
          beat_d  = beat_q + BEAT_W'(1);
          ld_beat = 1'b1;
          ld_widx = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      widx_q  <= '0;
      beat_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      write_q <= write_d;
      if (ld_widx) widx_q <= word_sel_i;
      if (ld_beat) beat_q <= beat_d;
      if (ld_last) last_q <= !last_n_i;
    end
  end

  assign state_o  = state_q;
  assign write_o  = write_q;
  assign widx_o   = widx_q;
  assign cap_en_o = (state_q == ST_IDLE) && ale_i;
  assign accept_o = (state_q == ST_BEAT) && ready_i;

  // R6: acknowledge only follows an accepted back-side request
  assert_ack_after_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK) |-> $past(state_q == ST_BEAT && ready_i));
  // R6: acknowledge lasts one cycle
  assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK) |=> (state_q != ST_ACK));
  // R10: beat limit closes the transfer
  assert_burst_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK && beat_q == BEAT_END) |=> (state_q == ST_IDLE));
  // R9: a marked final beat closes the transfer
  assert_last_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK && last_q) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target
  import mbt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int WIDX_W    = 2,
  parameter int SIZE_W    = 2,
  parameter int MAX_BEATS = 4,
  localparam int LANES    = DATA_W / 8,
  localparam int BOFF_W   = $clog2(LANES),
  localparam int WADDR_W  = DATA_W - BOFF_W,
  localparam int HI_W     = WADDR_W - WIDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  bus_ad_i,
  output logic [DATA_W-1:0]  bus_ad_o,
  output logic               bus_ad_oe,
  input  logic               ale_i,
  input  logic [WIDX_W-1:0]  word_sel_i,
  input  logic [SIZE_W-1:0]  width_i,
  input  logic               cip_n_i,
  input  logic               rd_n_i,
  input  logic               wr_n_i,
  input  logic               dir_rd_i,
  input  logic               data_en_n_i,
  input  logic               last_n_i,
  output logic               ack_n_o,
  output logic               req_valid_o,
  output logic               req_write_o,
  output logic [WADDR_W-1:0] req_addr_o,
  output logic [LANES-1:0]   req_be_o,
  output logic [DATA_W-1:0]  req_wdata_o,
  input  logic [DATA_W-1:0]  req_rdata_i,
  input  logic               req_ready_i
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  mbt_state_e        state;
  logic              write;
  logic [WIDX_W-1:0] widx;
  logic              cap_en, accept;
  logic [HI_W-1:0]   addr_hi;
  logic [BOFF_W-1:0] boff;
  logic [SIZE_W-1:0] size;
  logic [DATA_W-1:0] rdata_q;
  logic              rdata_en;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  mbt_fsm #(.MAX_BEATS(MAX_BEATS), .WIDX_W(WIDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .ale_i(ale_i), .cip_n_i(cip_n_i),
    .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .dir_rd_i(dir_rd_i), .last_n_i(last_n_i),
    .word_sel_i(word_sel_i), .ready_i(req_ready_i), .state_o(state),
    .write_o(write), .widx_o(widx), .cap_en_o(cap_en), .accept_o(accept)
  );

  mbt_addr_latch #(.DATA_W(DATA_W), .WIDX_W(WIDX_W), .SIZE_W(SIZE_W)) u_latch (
    .clk(clk), .rst_n(rst_core_n), .cap_en_i(cap_en), .bus_i(bus_ad_i),
    .size_i(width_i), .hi_o(addr_hi), .boff_o(boff), .size_o(size)
  );

  mbt_lane_gen #(.LANES(LANES), .SIZE_W(SIZE_W)) u_lanes (
    .boff_i(boff), .size_i(size), .be_o(req_be_o)
  );

  // read data holding register, loaded on an accepted read beat
  assign rdata_en = accept && !write;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)   rdata_q <= '0;
    else if (rdata_en) rdata_q <= req_rdata_i;
  end

  assign req_valid_o = (state == ST_BEAT);
  assign req_write_o = write;
  assign req_addr_o  = {addr_hi, widx};
  assign req_wdata_o = bus_ad_i;
  assign ack_n_o     = !(state == ST_ACK);
  assign bus_ad_o    = rdata_q;
  assign bus_ad_oe   = (state == ST_ACK) && !write && !data_en_n_i;

  // R7: the shared lines are driven only in a read acknowledge with data enabled
  assert_drive_window_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    bus_ad_oe |-> (!ack_n_o && !req_write_o && !data_en_n_i));
  // R5: a request always carries at least one byte lane
  assert_lanes_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    req_valid_o |-> (req_be_o != '0));
  // R1: nothing is driven or acknowledged while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == ST_IDLE) |-> (ack_n_o && !bus_ad_oe && !req_valid_o));
endmodule

// File: tb/mux_bus_target_test.sv
`timescale 1ns/1ps
module mux_bus_target_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bus_in;
  logic [31:0] bus_ad_o;
  logic        bus_ad_oe;
  logic        ale;
  logic [1:0]  word_sel;
  logic [1:0]  width;
  logic        cip_n, rd_n, wr_n, dir_rd, data_en_n, last_n;
  logic        ack_n_o, req_valid_o, req_write_o;
  logic [29:0] req_addr_o;
  logic [3:0]  req_be_o;
  logic [31:0] req_wdata_o, req_rdata_i;
  logic        req_ready_i;

  int errors = 0;
  int checks = 0;
  int wait_cfg = 0;
  int wcnt = 0;
  logic [31:0] mem [0:15];
  logic [31:0] exp_mem [0:15];

  always #2.5 clk = ~clk;

  mux_bus_target uut (
    .clk(clk), .rst_n(rst_n), .bus_ad_i(bus_in), .bus_ad_o(bus_ad_o),
    .bus_ad_oe(bus_ad_oe), .ale_i(ale), .word_sel_i(word_sel), .width_i(width),
    .cip_n_i(cip_n), .rd_n_i(rd_n), .wr_n_i(wr_n), .dir_rd_i(dir_rd),
    .data_en_n_i(data_en_n), .last_n_i(last_n), .ack_n_o(ack_n_o),
    .req_valid_o(req_valid_o), .req_write_o(req_write_o), .req_addr_o(req_addr_o),
    .req_be_o(req_be_o), .req_wdata_o(req_wdata_o), .req_rdata_i(req_rdata_i),
    .req_ready_i(req_ready_i)
  );

  function automatic logic [31:0] seed_word(input int i);
    return 32'h5A00_0000 ^ (i * 32'h0103_0507);
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] off, input logic [1:0] wd);
    logic [3:0] r = '0;
    for (int l = 0; l < 4; l++)
      if (l >= int'(off) && (l - int'(off)) <= int'(wd)) r[l] = 1'b1;
    return r;
  endfunction

  // back-side peripheral model
  assign req_ready_i = req_valid_o && (wcnt == wait_cfg);
  assign req_rdata_i = mem[req_addr_o[3:0]];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= seed_word(i);
    end else if (req_valid_o && req_ready_i && req_write_o) begin
      for (int l = 0; l < 4; l++)
        if (req_be_o[l]) mem[req_addr_o[3:0]][8*l +: 8] <= req_wdata_o[8*l +: 8];
    end
    if (!req_valid_o || req_ready_i) wcnt <= 0;
    else wcnt <= wcnt + 1;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle_bus();
    ale = 0; rd_n = 1; wr_n = 1; cip_n = 1; last_n = 1; data_en_n = 1;
    dir_rd = 0; bus_in = 32'h0; word_sel = 2'd0; width = 2'd3;
  endtask

  task automatic do_xfer(input logic wr, input logic [31:0] addr, input logic [1:0] wd,
                         input int nb, input logic use_last, input int wt,
                         input logic [31:0] wdat, input logic den_off, input logic hold,
                         input string hold_tag);
    logic [3:0]  ebe;
    logic [1:0]  wi;
    logic [3:0]  ix;
    logic [31:0] bdat;
    logic        seen;
    int          n;
    ebe = exp_be(addr[1:0], wd);
    wait_cfg = wt;
    @(negedge clk);
    ale = 1; bus_in = addr; width = wd;
    @(negedge clk);
    ale = 0; cip_n = 0; dir_rd = !wr; rd_n = wr; wr_n = !wr;
    bus_in = wr ? wdat : 32'hFFFF_FFFF;
    data_en_n = wr ? 1'b1 : den_off;
    word_sel = addr[3:2];
    last_n = !(use_last && nb == 1);
    for (int b = 0; b < nb; b++) begin
      wi = addr[3:2] + 2'(b);
      ix = {addr[5:4], wi};
      bdat = wdat + 32'(b);
      n = 0; seen = 0;
      do begin
        @(negedge clk);
        n++;
        if (req_valid_o && !seen) begin
          seen = 1;
          chk("R2 upper address", {4'h0, req_addr_o[29:2]}, {4'h0, addr[31:4]});
          chk("R3 word index", {30'h0, req_addr_o[1:0]}, {30'h0, wi});
          chk("R5 byte enables", {28'h0, req_be_o}, {28'h0, ebe});
          chk("R8 write flag", {31'h0, req_write_o}, {31'h0, wr});
          if (wr) chk("R8 write data", req_wdata_o, bdat);
        end
      end while (ack_n_o && n < 30);
      chk("R6 acknowledge latency", 32'(n), 32'(wt + 2));
      if (!wr) begin
        if (den_off) begin
          chk("R7 drive held off", {31'h0, bus_ad_oe}, 32'h0);
        end else begin
          chk("R7 drive on", {31'h0, bus_ad_oe}, 32'h1);
          chk("R7 read data", bus_ad_o, exp_mem[ix]);
        end
      end else begin
        for (int l = 0; l < 4; l++)
          if (ebe[l]) exp_mem[ix][8*l +: 8] = bdat[8*l +: 8];
      end
      word_sel = addr[3:2] + 2'(b + 1);
      bus_in = wr ? wdat + 32'(b + 1) : 32'hFFFF_FFFF;
      last_n = !(use_last && (b + 1) == nb - 1);
    end
    @(negedge clk);
    chk("R6 acknowledge one cycle", {31'h0, ack_n_o}, 32'h1);
    if (hold) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk({hold_tag, " no request after end"}, {30'h0, req_valid_o, ack_n_o}, 32'h1);
      end
    end
    idle_bus();
  endtask

  // wr, addr, width, beats, last, wait, wdata
  localparam int NV = 9;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 32'hABCD_0010, 2'd3, 3'd1, 1'b1, 2'd0, 32'h0},
    {1'b1, 32'h1234_5624, 2'd3, 3'd1, 1'b1, 2'd1, 32'hDEAD_BEEF},
    {1'b0, 32'h0000_0024, 2'd3, 3'd1, 1'b1, 2'd2, 32'h0},
    {1'b1, 32'h0000_0031, 2'd0, 3'd1, 1'b1, 2'd0, 32'h1122_3344},
    {1'b0, 32'h0000_0030, 2'd3, 3'd1, 1'b1, 2'd0, 32'h0},
    {1'b1, 32'h0000_000A, 2'd3, 3'd1, 1'b1, 2'd0, 32'h9988_7766},
    {1'b0, 32'h0000_0008, 2'd3, 3'd1, 1'b1, 2'd1, 32'h0},
    {1'b1, 32'hF000_0038, 2'd3, 3'd3, 1'b1, 2'd3, 32'h0100_0000},
    {1'b0, 32'h0000_0038, 2'd3, 3'd3, 1'b1, 2'd0, 32'h0}
  };

  initial begin
    for (int i = 0; i < 16; i++) exp_mem[i] = seed_word(i);
    idle_bus();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset ack", {31'h0, ack_n_o}, 32'h1);
    chk("R1 reset drive", {31'h0, bus_ad_oe}, 32'h0);
    chk("R1 reset request", {31'h0, req_valid_o}, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {30'h0, req_valid_o, ack_n_o}, 32'h1);

    for (int v = 0; v < NV; v++) begin
      do_xfer(VEC[v][72], VEC[v][71:40], VEC[v][39:38], int'(VEC[v][37:35]),
              VEC[v][34], int'(VEC[v][33:32]), VEC[v][31:0], 1'b0, 1'b0, "R9");
    end

    // R9 and R10 on the same beat: four-beat read, last on beat four, wrapping index
    do_xfer(1'b0, 32'h0000_0004, 2'd3, 4, 1'b1, 1, 32'h0, 1'b0, 1'b1, "R9");
    // R10: four beats, no last marker, strobes held afterwards
    do_xfer(1'b0, 32'h0000_0030, 2'd3, 4, 1'b0, 0, 32'h0, 1'b0, 1'b1, "R10");
    // R7: acknowledge with data-enable held off
    do_xfer(1'b0, 32'h0000_0014, 2'd3, 1, 1'b1, 0, 32'h0, 1'b1, 1'b0, "R9");

    // R4: strobe and direction disagree
    @(negedge clk); ale = 1; bus_in = 32'h0000_0040;
    @(negedge clk); ale = 0; cip_n = 0; rd_n = 0; dir_rd = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R4 read with wrong direction", {31'h0, req_valid_o}, 32'h0);
    end
    rd_n = 1; wr_n = 0; dir_rd = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R4 write with wrong direction", {31'h0, req_valid_o}, 32'h0);
    end
    idle_bus();
    @(negedge clk);

    // R11: cycle dropped before any strobe
    ale = 1; bus_in = 32'h0000_0050;
    @(negedge clk); ale = 0;
    @(negedge clk); @(negedge clk);
    cip_n = 0; rd_n = 0; dir_rd = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 no request after abort", {30'h0, req_valid_o, ack_n_o}, 32'h1);
    end
    idle_bus();
    do_xfer(1'b0, 32'h0000_0010, 2'd3, 1, 1'b1, 0, 32'h0, 1'b0, 1'b0, "R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule